// File: doc/BRIEF.md
# Phase-Accumulator Baud Tick Generator

This block turns a fast system clock into a single-cycle enable pulse whose average rate is sixteen times a chosen baud rate, for use as the oversampling strobe of a serial receiver and transmitter. The pulse is an enable that downstream logic qualifies its registers with; it never drives a clock pin. The rate comes from the overflow of an N-bit phase accumulator. The accumulator grows by a fixed increment on every system clock, so any system clock frequency can be served with a frequency error that shrinks as N grows.

The increments are computed at elaboration from the clock frequency parameter and a parameter list of baud rates. A select input chooses one of them while the block runs. A build-time variant ties the increment to one constant rate and disregards the select. With a 49.152 MHz clock and 115200 baud, the target pulse rate is 1.8432 MHz.

Top module: `baud_tick_dds`

## Requirements
- R1: Reset input `rst_n` is active low and asynchronous. While it is low, `tick_o` is 0 and the accumulator is cleared. After it rises, two rising clock edges pass with no add, and the first add happens on the third rising edge.
- R2: Out of reset, every rising edge adds the current increment to the N-bit accumulator modulo 2^N. `tick_o` is 1 for exactly the one cycle that follows an add which overflowed, and 0 otherwise.
- R3: The increment for baud rate B is floor((16·B·2^N + CLK_HZ/2) / CLK_HZ), which is 16·B·2^N/CLK_HZ rounded to the nearest integer.
- R4: `rate_sel` value k selects entry k of the rate list. With the default list, 0 is 9600, 1 is 19200, 2 is 57600 and 3 is 115200 baud.
- R5: A new `rate_sel` value is used by the very next add. The accumulator phase is carried over and not cleared.
- R6: Over any 2^N consecutive adds with a constant selection, `tick_o` is high in exactly increment-many cycles.
- R7: When the increment is at most half of 2^N, no two consecutive cycles both have `tick_o` high.
- R8: With the fixed-rate variant enabled, the increment is always that of the parameter FIXED_BAUD, and `rate_sel` has no effect on `tick_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | SEL_W | Index into the baud rate list |
| tick_o | output | 1 | One-cycle enable at sixteen times the selected baud |

## Verification
The hardest case to reach is an overflow that lands on the same edge where the selection changes: the leftover phase from the old rate must carry into the new one. Ports alone show only isolated pulses. The bench therefore keeps a cycle-exact model of the accumulator and compares every cycle while it flips `rate_sel` at random moments, so selection changes fall at every phase. Full 2^N windows at each fixed selection then count the pulses against the computed increments. A second instance in the fixed-rate variant gets the same random selections to show that they have no effect.

// File: rtl/baud_dds_pkg.sv
package baud_dds_pkg;

  // Rounded phase step that yields 16*baud overflow pulses per second.
  function automatic longint unsigned calc_inc(input longint unsigned baud,
                                               input longint unsigned clk_hz,
                                               input int unsigned     acc_w);
    longint unsigned scaled;
    scaled = (baud * 64'd16) << acc_w;
    return (scaled + (clk_hz / 64'd2)) / clk_hz;
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/baud_inc_table.sv
module baud_inc_table #(
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned CLK_HZ     = 49_152_000,
  parameter int unsigned NUM_RATES  = 4,
  parameter int unsigned BAUD_LIST [NUM_RATES] = '{9600, 19200, 57600, 115200},
  parameter bit          FIXED_RATE = 1'b0,
  parameter int unsigned FIXED_BAUD = 115200,
  parameter int unsigned SEL_W      = 2
) (
  input  logic [SEL_W-1:0] sel,
  output logic [ACC_W-1:0] inc
);
  import baud_dds_pkg::*;

  generate
    if (FIXED_RATE) begin : g_fixed
      localparam logic [ACC_W-1:0] FIXED_INC =
        ACC_W'(calc_inc(64'(FIXED_BAUD), 64'(CLK_HZ), ACC_W));
      logic unused_sel;
      assign unused_sel = ^sel;
      assign inc = FIXED_INC;
    end else begin : g_table
      logic [ACC_W-1:0] step_tab [NUM_RATES];
      for (genvar k = 0; k < NUM_RATES; k++) begin : g_entry
        assign step_tab[k] = ACC_W'(calc_inc(64'(BAUD_LIST[k]), 64'(CLK_HZ), ACC_W));
      end
      if (NUM_RATES == (1 << SEL_W)) begin : g_full
        assign inc = step_tab[sel];
      end else begin : g_guard
        always_comb begin
          if (32'(sel) < NUM_RATES) inc = step_tab[sel];
          else                      inc = step_tab[0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_o,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, inc};
    acc_d  = sum[ACC_W-1:0];
    tick_d = sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign acc_o  = acc_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/baud_tick_dds.sv
module baud_tick_dds #(
  parameter int unsigned CLK_HZ     = 49_152_000,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned NUM_RATES  = 4,
  parameter int unsigned BAUD_LIST [NUM_RATES] = '{9600, 19200, 57600, 115200},
  parameter bit          FIXED_RATE = 1'b0,
  parameter int unsigned FIXED_BAUD = 115200,
  localparam int unsigned SEL_W     = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick_o
);
  logic             rst_int_n;
  logic [ACC_W-1:0] inc_w;
  logic [ACC_W-1:0] acc_w;

  baud_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  baud_inc_table #(
    .ACC_W      (ACC_W),
    .CLK_HZ     (CLK_HZ),
    .NUM_RATES  (NUM_RATES),
    .BAUD_LIST  (BAUD_LIST),
    .FIXED_RATE (FIXED_RATE),
    .FIXED_BAUD (FIXED_BAUD),
    .SEL_W      (SEL_W)
  ) u_table (
    .sel (rate_sel),
    .inc (inc_w)
  );

  baud_phase_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .inc    (inc_w),
    .acc_o  (acc_w),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/baud_tick_dds_chk.sv
module baud_tick_dds_chk #(
  parameter int unsigned ACC_W      = 16,
  parameter bit          FIXED_RATE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic [ACC_W-1:0] inc,
  input logic [ACC_W-1:0] acc,
  input logic             tick
);
  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= rst_int_n;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> !tick);                                              // R1

  AST_WRAP_REMAINDER: assert property (@(posedge clk) disable iff (!armed)
    tick |-> (acc < $past(inc)));                                       // R2

  AST_NO_WRAP_FLOOR: assert property (@(posedge clk) disable iff (!armed)
    !tick |-> (acc >= $past(inc)));                                     // R2

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!armed)
    (tick && (inc <= HALF) && ($past(inc) <= HALF)) |=> !tick);         // R7

  generate
    if (FIXED_RATE) begin : g_fixed_chk
      AST_FIXED_INC: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(inc));                                                  // R8
    end
  endgenerate
endmodule

bind baud_tick_dds baud_tick_dds_chk #(
  .ACC_W      (ACC_W),
  .FIXED_RATE (FIXED_RATE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .inc       (inc_w),
  .acc       (acc_w),
  .tick      (tick_o)
);

// File: tb/baud_tick_dds_tb.sv
module baud_tick_dds_tb;
  localparam int unsigned ACC  = 12;
  localparam int unsigned FCLK = 49_152_000;
  localparam int unsigned FIXB = 57600;
  localparam int unsigned WIN  = 1 << ACC;

  logic       clk;
  logic       rst_n;
  logic [1:0] sel;
  logic       tick_o;
  logic       tick_fix;

  int n_checks = 0;
  int n_err    = 0;
  bit cmp_en   = 0;
  bit done     = 0;

  baud_tick_dds #(.CLK_HZ(FCLK), .ACC_W(ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(sel), .tick_o(tick_o));

  baud_tick_dds #(.CLK_HZ(FCLK), .ACC_W(ACC), .FIXED_RATE(1'b1), .FIXED_BAUD(FIXB)) u_fix (
    .clk(clk), .rst_n(rst_n), .rate_sel(sel), .tick_o(tick_fix));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned baud_of(input int unsigned s);
    case (s)
      0: return 9600;
      1: return 19200;
      2: return 57600;
      default: return 115200;
    endcase
  endfunction

  function automatic longint unsigned exp_inc(input longint unsigned baud);
    return ((baud * 16 * (64'd1 << ACC)) + FCLK / 2) / FCLK;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference models of both instances
  longint unsigned m_acc, f_acc;
  bit m_tick, f_tick;
  int rcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; m_acc = 0; f_acc = 0; m_tick = 0; f_tick = 0;
    end else if (rcnt < 2) begin
      rcnt++; m_tick = 0; f_tick = 0;
    end else begin
      m_acc  = m_acc + exp_inc(baud_of(sel));
      m_tick = m_acc >= WIN;
      m_acc  = m_acc % WIN;
      f_acc  = f_acc + exp_inc(FIXB);
      f_tick = f_acc >= WIN;
      f_acc  = f_acc % WIN;
    end
  end

  bit prev_tick = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tick_o == m_tick, "R2/R5 tick vs model", tick_o, m_tick);
      chk(tick_fix == f_tick, "R8 fixed tick vs model", tick_fix, f_tick);
      chk(!(prev_tick && tick_o), "R7 back-to-back tick", tick_o, 0);
    end
    prev_tick = tick_o;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    cmp_en = 0;
    repeat (3) begin
      @(negedge clk);
      chk(tick_o == 0, "R1 tick during reset", tick_o, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(tick_o == 0 && tick_fix == 0, "R1 quiet after release", tick_o, 0);
    end
    cmp_en = 1;
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd20240917));
    rst_n = 1'b1;
    sel   = 2'd3;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick_o == 0 && tick_fix == 0, "R1 reset state", tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick_o == 0, "R1 first cycle after release", tick_o, 0);
    cmp_en = 1;

    // Full windows per selection: ticks equal the computed increment
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      sel = 2'(s);
      cnt = 0;
      for (int i = 0; i < WIN; i++) begin
        @(negedge clk);
        if (tick_o) cnt++;
      end
      chk(longint'(cnt) == longint'(exp_inc(baud_of(s))), $sformatf("R3/R4/R6 window sel=%0d", s),
          cnt, exp_inc(baud_of(s)));
    end

    // Fixed variant window while select keeps moving
    cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (tick_fix) cnt++;
      if (($urandom % 4) == 0) sel = 2'($urandom);
    end
    chk(longint'(cnt) == longint'(exp_inc(FIXB)), "R8 fixed window", cnt, exp_inc(FIXB));

    // Random selection changes mixed with the model comparison
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 8) == 0) sel = 2'($urandom);
    end

    // Directed: change select right after an overflow cycle
    for (int i = 0; i < 4; i++) begin
      while (!tick_o) @(negedge clk);
      sel = 2'((sel + 1) % 4);
      @(negedge clk);
    end

    // Mid-run reset then more random activity
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (($urandom % 5) == 0) sel = 2'($urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule